// File: doc/BRIEF.md
# Three-State Power Mode Sequencer

This block sequences a processor core through three operating modes: full operation (RUN), a halted state in which the core stops but interrupts are still watched (IDLE), and a deep state in which all on-chip activity is shut down (SLEEP). Software asks for IDLE or SLEEP through single-cycle request inputs. An interrupt brings the core back from IDLE. A dedicated wakeup input brings it back from SLEEP.

Each move between modes has its own latency, counted in clock cycles. Each latency is set as a time in microseconds multiplied by a cycles-per-microsecond parameter. The defaults are 10 µs between RUN and IDLE in either direction, 90 µs to enter SLEEP and 160 ms to wake from it. A busy flag stays high while a move is in progress. The block reports the current mode, a clock-gate enable, a shutdown enable and a 2-bit code for the nominal power level.

Because the wake path is far slower than the others, the rule for events that arrive during a move is fixed. Such events are dropped, with one exception: an interrupt that arrives on the way into IDLE is kept, and it turns the core straight back to RUN.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is RUN, busy is low, the clock-gate enable is 1, shutdown is 0 and the power code is 2'b11. Mode codes are RUN=0, IDLE=1 and SLEEP=2.
- R2: Suppose the core is in RUN, not busy, and req_idle is sampled high at an edge. Busy is then high for exactly LAT_RI cycles (CYC_PER_US*RUN_IDLE_US). The mode reads IDLE after the last of those cycles. Every latency is at least one cycle.
- R3: In IDLE and not busy, a sampled interrupt starts a return to RUN that lasts LAT_RI cycles of busy.
- R4: In RUN and not busy, a sampled req_sleep starts entry to SLEEP that lasts LAT_SL cycles (CYC_PER_US*SLEEP_ENTER_US). If req_sleep and req_idle are sampled together, req_sleep wins.
- R5: In SLEEP and not busy, a sampled wake starts a return to RUN that lasts LAT_WK cycles (CYC_PER_US*WAKE_US).
- R6: In SLEEP, interrupts and both software requests have no effect. Only wake is honoured.
- R7: While busy, all inputs are dropped except the case in R8. In IDLE the software requests are ignored, and wake is ignored outside SLEEP.
- R8: An interrupt sampled during a RUN-to-IDLE move, up to and including its final cycle, is held. When that move ends, the mode reads IDLE and busy stays high without a gap. A return to RUN of LAT_RI cycles follows at once.
- R9: The clock-gate enable is 1 only in RUN, and shutdown is 1 only in SLEEP. The power code is 2'b11 in RUN, 2'b01 in IDLE and 2'b00 in SLEEP. These outputs follow the reported mode in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_idle_i | input | 1 | Software request to enter IDLE |
| req_sleep_i | input | 1 | Software request to enter SLEEP |
| irq_i | input | 1 | Interrupt event |
| wake_i | input | 1 | Dedicated wakeup event |
| mode_o | output | 2 | Current mode code |
| clk_en_o | output | 1 | Core clock-gate enable |
| shutdown_o | output | 1 | On-chip shutdown enable |
| busy_o | output | 1 | A mode move is in progress |
| plvl_o | output | 2 | Nominal power-level code |

## Verification
An input sampled at edge k makes busy rise right after edge k. The new mode appears right after edge k+LAT, where LAT is the latency of that move. The clock, shutdown and power outputs change in the same cycle as the mode. The bench keeps a behavioural model that advances on the same edge and holds an integer count of remaining cycles. It drives inputs and compares every output on the falling edge, so each result is checked in the exact cycle it is due. Short latencies are used so that every move, including the held-interrupt return and the wake path, completes many times within the run.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_IDLE  = 2'd1,
        MODE_SLEEP = 2'd2
    } pm_mode_e;

    typedef enum logic [2:0] {
        XF_NONE     = 3'd0,
        XF_TO_IDLE  = 3'd1,
        XF_TO_RUN   = 3'd2,
        XF_TO_SLEEP = 3'd3,
        XF_WAKE     = 3'd4
    } pm_xfer_e;

    localparam logic [1:0] PLVL_RUN   = 2'b11;
    localparam logic [1:0] PLVL_IDLE  = 2'b01;
    localparam logic [1:0] PLVL_SLEEP = 2'b00;

endpackage

// File: rtl/pwr_lat_cnt.sv
module pwr_lat_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             done_o,
    output logic             active_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o   = (cnt_q == CNT_W'(1));
    assign active_o = (cnt_q != '0);

    // R2: every move lasts at least one cycle
    assert_load_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> active_o);

    // R2: the count only falls by one per cycle between loads
    assert_count_steps_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(active_o) && !$past(load_i)) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/pwr_mode_dec.sv
module pwr_mode_dec
    import pwr_mode_pkg::*;
(
    input  pm_mode_e   mode_i,
    output logic       clk_en_o,
    output logic       shutdown_o,
    output logic [1:0] plvl_o
);

    always_comb begin
        clk_en_o   = 1'b0;
        shutdown_o = 1'b0;
        plvl_o     = PLVL_RUN;
        case (mode_i)
            MODE_RUN: begin
                clk_en_o = 1'b1;
                plvl_o   = PLVL_RUN;
            end
            MODE_IDLE: begin
                plvl_o = PLVL_IDLE;
            end
            MODE_SLEEP: begin
                shutdown_o = 1'b1;
                plvl_o     = PLVL_SLEEP;
            end
            default: begin
                clk_en_o = 1'b1;
                plvl_o   = PLVL_RUN;
            end
        endcase
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int CYC_PER_US     = 125,
    parameter int RUN_IDLE_US    = 10,
    parameter int SLEEP_ENTER_US = 90,
    parameter int WAKE_US        = 160000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       req_idle_i,
    input  logic       req_sleep_i,
    input  logic       irq_i,
    input  logic       wake_i,
    output logic [1:0] mode_o,
    output logic       clk_en_o,
    output logic       shutdown_o,
    output logic       busy_o,
    output logic [1:0] plvl_o
);

    localparam int LAT_RI  = CYC_PER_US * RUN_IDLE_US;
    localparam int LAT_SL  = CYC_PER_US * SLEEP_ENTER_US;
    localparam int LAT_WK  = CYC_PER_US * WAKE_US;
    localparam int LAT_MAX = (LAT_WK > LAT_SL) ? ((LAT_WK > LAT_RI) ? LAT_WK : LAT_RI)
                                               : ((LAT_SL > LAT_RI) ? LAT_SL : LAT_RI);
    localparam int CNT_W   = $clog2(LAT_MAX + 1);

    localparam logic [CNT_W-1:0] LD_RI = CNT_W'(LAT_RI);
    localparam logic [CNT_W-1:0] LD_SL = CNT_W'(LAT_SL);
    localparam logic [CNT_W-1:0] LD_WK = CNT_W'(LAT_WK);

    typedef struct packed {
        pm_mode_e mode;
        pm_xfer_e xfer;
        logic     pend;
    } pm_state_t;

    pm_state_t        st_d, st_q;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             cnt_done;
    logic             cnt_active;

    always_comb begin
        st_d     = st_q;
        load     = 1'b0;
        load_val = '0;
        if (st_q.xfer == XF_NONE) begin
            case (st_q.mode)
                MODE_RUN: begin
                    if (req_sleep_i) begin
                        st_d.xfer = XF_TO_SLEEP;
                        load      = 1'b1;
                        load_val  = LD_SL;
                    end else if (req_idle_i) begin
                        st_d.xfer = XF_TO_IDLE;
                        st_d.pend = 1'b0;
                        load      = 1'b1;
                        load_val  = LD_RI;
                    end
                end
                MODE_IDLE: begin
                    if (irq_i) begin
                        st_d.xfer = XF_TO_RUN;
                        load      = 1'b1;
                        load_val  = LD_RI;
                    end
                end
                MODE_SLEEP: begin
                    if (wake_i) begin
                        st_d.xfer = XF_WAKE;
                        load      = 1'b1;
                        load_val  = LD_WK;
                    end
                end
                default: st_d.mode = MODE_RUN;
            endcase
        end else if (cnt_done) begin
            st_d.xfer = XF_NONE;
            st_d.pend = 1'b0;
            case (st_q.xfer)
                XF_TO_IDLE: begin
                    st_d.mode = MODE_IDLE;
                    if (st_q.pend || irq_i) begin
                        st_d.xfer = XF_TO_RUN;
                        load      = 1'b1;
                        load_val  = LD_RI;
                    end
                end
                XF_TO_SLEEP: st_d.mode = MODE_SLEEP;
                default:     st_d.mode = MODE_RUN;
            endcase
        end else if (st_q.xfer == XF_TO_IDLE && irq_i) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{mode: MODE_RUN, xfer: XF_NONE, pend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    pwr_lat_cnt #(
        .CNT_W(CNT_W)
    ) lat_cnt_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (load),
        .load_val_i(load_val),
        .done_o    (cnt_done),
        .active_o  (cnt_active)
    );

    pwr_mode_dec mode_dec_i (
        .mode_i    (st_q.mode),
        .clk_en_o  (clk_en_o),
        .shutdown_o(shutdown_o),
        .plvl_o    (plvl_o)
    );

    assign mode_o = st_q.mode;
    assign busy_o = (st_q.xfer != XF_NONE);

    // R7: busy is reported exactly while the latency counter runs
    assert_busy_tracks_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o == cnt_active);

    // R2: the mode changes only at the end of a move
    assert_mode_moves_when_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o != $past(mode_o)) |-> $past(busy_o));

    // R6: without wake, SLEEP is left alone
    assert_sleep_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == MODE_SLEEP && !busy_o && !wake_i) |=> (mode_o == MODE_SLEEP && !busy_o));

    // R8: a held interrupt keeps busy high across the IDLE arrival
    assert_held_irq_returns_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.xfer == XF_TO_IDLE && cnt_done && (st_q.pend || irq_i))
            |=> (busy_o && mode_o == MODE_IDLE));

    // R9: gate enable and shutdown never both high
    assert_outputs_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({clk_en_o, shutdown_o}));

endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb_top;

    localparam int CPU = 1;
    localparam int RI  = 4;
    localparam int SL  = 9;
    localparam int WK  = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_idle = 1'b0, req_sleep = 1'b0, irq = 1'b0, wake = 1'b0;
    logic [1:0] mode, plvl;
    logic clk_en, shutdown, busy;

    always #4 clk = ~clk;

    pwr_mode_ctrl #(
        .CYC_PER_US    (CPU),
        .RUN_IDLE_US   (RI),
        .SLEEP_ENTER_US(SL),
        .WAKE_US       (WK)
    ) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .req_idle_i (req_idle),
        .req_sleep_i(req_sleep),
        .irq_i      (irq),
        .wake_i     (wake),
        .mode_o     (mode),
        .clk_en_o   (clk_en),
        .shutdown_o (shutdown),
        .busy_o     (busy),
        .plvl_o     (plvl)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    string phase = "R1";

    // reference model: mode 0 RUN, 1 IDLE, 2 SLEEP; rem = cycles of busy left
    int m_mode = 0;
    int m_rem  = 0;
    int m_dest = 0;
    bit m_toidle = 1'b0;
    bit m_held   = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_rem = 0; m_dest = 0; m_toidle = 0; m_held = 0;
        end else if (m_rem > 0) begin
            if (m_rem == 1) begin
                m_mode = m_dest;
                m_rem  = 0;
                if (m_toidle && (m_held || irq)) begin
                    m_dest = 0; m_rem = RI * CPU;
                end
                m_toidle = 0; m_held = 0;
            end else begin
                m_rem = m_rem - 1;
                if (m_toidle && irq) m_held = 1;
            end
        end else begin
            if (m_mode == 0 && req_sleep) begin
                m_dest = 2; m_rem = SL * CPU;
            end else if (m_mode == 0 && req_idle) begin
                m_dest = 1; m_rem = RI * CPU; m_toidle = 1;
            end else if (m_mode == 1 && irq) begin
                m_dest = 0; m_rem = RI * CPU;
            end else if (m_mode == 2 && wake) begin
                m_dest = 0; m_rem = WK * CPU;
            end
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk(phase, "mode", int'(mode), m_mode);
            chk(phase, "busy", int'(busy), (m_rem > 0) ? 1 : 0);
            chk("R9", "clk_en", int'(clk_en), (m_mode == 0) ? 1 : 0);
            chk("R9", "shutdown", int'(shutdown), (m_mode == 2) ? 1 : 0);
            chk("R9", "plvl", int'(plvl), (m_mode == 0) ? 3 : (m_mode == 1) ? 1 : 0);
        end
        if (cycles > 20000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic idle_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    logic [15:0] lfsr = 16'hACE1;

    initial begin
        idle_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, checked directly as well as against the model
        chk("R1", "reset mode", int'(mode), 0);
        chk("R1", "reset busy", int'(busy), 0);
        chk("R1", "reset plvl", int'(plvl), 3);
        idle_cyc(2);

        phase = "R2"; pulse(req_idle); idle_cyc(6);
        phase = "R7"; pulse(req_sleep); pulse(req_idle); pulse(wake); idle_cyc(2);
        phase = "R3"; pulse(irq); idle_cyc(6);
        phase = "R4"; req_idle = 1'b1; req_sleep = 1'b1; @(negedge clk);
        req_idle = 1'b0; req_sleep = 1'b0;
        phase = "R7"; idle_cyc(2); pulse(req_idle); pulse(irq); pulse(wake); idle_cyc(10);
        phase = "R6"; pulse(irq); pulse(req_idle); pulse(req_sleep); idle_cyc(3);
        phase = "R5"; pulse(wake); idle_cyc(3); pulse(wake); pulse(irq); idle_cyc(40);
        phase = "R8"; pulse(req_idle); pulse(irq); idle_cyc(12);
        pulse(req_idle); idle_cyc(2); pulse(irq); idle_cyc(12);
        pulse(req_idle); idle_cyc(3); pulse(irq); idle_cyc(12);
        phase = "R7";
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            req_idle  = (lfsr[3:0] == 4'h1);
            req_sleep = (lfsr[7:3] == 5'h05);
            irq       = (lfsr[11:8] == 4'h2);
            wake      = (lfsr[15:12] == 4'h3);
            @(negedge clk);
        end
        req_idle = 0; req_sleep = 0; irq = 0; wake = 0;
        idle_cyc(50);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule